// File: doc/BRIEF.md
# Elitist Single-Individual Search Sequencer

This block runs a genetic search without a population store. It keeps two records, each a chromosome with its fitness. The global record is the best individual seen in the whole run. The local record is the best individual of the current iteration. A run begins with one random draw that seeds the global record.

Each global iteration then samples `POP_N` random individuals and keeps the fittest of them as the local record. After that, rounds of `ROUND_M` micro-mutated candidates refine the local record. A separate mutation unit builds these candidates around the local record. This block tells that unit when to restore its range and when to narrow it. When the local record has stalled for `K_GENS` rounds, it competes with the global record. The run finishes once the global record has stalled for `T_GENS` iterations.

Fitness is computed outside the block. Each candidate is shown on a port, and its fitness value returns on the following cycle. This lets any combinational fitness function be attached.

Top module: `es_search_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `cand_valid_o`, `mut_req_o`, `mut_shrink_o` and `mut_restart_o` are 0, and `best_chrom_o` and `best_fit_o` are 0.
- R2: A `start_i` pulse in idle begins a run and raises `busy_o`. A `start_i` while busy has no effect on the sequence of candidates or on the result.
- R3: Random individuals come from a 32-bit shift register loaded with `SEED` at reset. Its next state is `{s[30:0], s[31]^s[21]^s[1]^s[0]}`. Each draw takes the current value and then advances the register once. The register is not reloaded between runs.
- R4: The first candidate of a run is a random draw, and it becomes the global record together with its fitness.
- R5: Each iteration presents `POP_N` random candidates. The first is taken as the local record unconditionally. Each later one replaces it only if its fitness is strictly greater (unsigned).
- R6: A candidate is presented with `cand_valid_o` high for one cycle. `cand_o` is then held for the next cycle, and `fit_i` is sampled in that next cycle.
- R7: Before each mutated candidate, `mut_req_o` pulses for one cycle while `mut_base_o` shows the local record. The value on `mut_cand_i` in that cycle is presented on the next cycle. It replaces the local record only if its fitness is strictly greater.
- R8: Mutated candidates come in rounds of `ROUND_M`. A round with no replacement ends with a one-cycle `mut_shrink_o` pulse.
- R9: The local phase ends after `K_GENS` consecutive rounds without replacement.
- R10: `mut_restart_o` pulses once per iteration, in the cycle the last sampled candidate is evaluated, before any mutated candidate.
- R11: At the end of a local phase, the local record replaces the global record only if its fitness is strictly greater. The run ends after `T_GENS` consecutive iterations without replacement.
- R12: At the end of a run, `done_o` pulses for one cycle. `best_chrom_o` and `best_fit_o` then stay stable until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cand_o | output | CHROM_W | Candidate under evaluation |
| cand_valid_o | output | 1 | Candidate presented this cycle |
| fit_i | input | FIT_W | Fitness of the candidate, one cycle after presentation |
| mut_base_o | output | CHROM_W | Local record, base for mutation |
| mut_req_o | output | 1 | Mutation unit: supply a candidate now |
| mut_cand_i | input | CHROM_W | Mutated candidate from the mutation unit |
| mut_shrink_o | output | 1 | Mutation unit: narrow the range |
| mut_restart_o | output | 1 | Mutation unit: restore the initial range |
| best_chrom_o | output | CHROM_W | Global record chromosome |
| best_fit_o | output | FIT_W | Global record fitness |

## Verification
The hardest cases to reach are the strict-comparison paths, where a candidate ties the record, and the full stall exit. In that exit, every iteration ends with `K_GENS` shrink pulses and the global record is never replaced. A constant fitness function reaches both: every comparison is a tie, so the seed draw must survive as the result, and the pulse counts follow exactly from the parameters.

A target-matching function and an identity function each give long runs with many replacements. These runs are checked candidate by candidate against a transaction model. The bench holds its own mutation unit, whose range follows the shrink and restart pulses. A second start pulse is issued in the middle of one run.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int LFSR_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEED_EV,
    ST_SEED_W,
    ST_POP_EV,
    ST_POP_W,
    ST_MUT_GEN,
    ST_MUT_EV,
    ST_MUT_W,
    ST_PROMOTE,
    ST_FIN
  } es_state_e;

  // maximal-length feedback, taps 32/22/2/1
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // per-lane seed scramble so lanes never share a state
  function automatic logic [LFSR_W-1:0] lane_seed(input logic [LFSR_W-1:0] base, input int lane);
    logic [LFSR_W-1:0] s;
    s = base ^ (LFSR_W'(lane) * 32'h9E37_79B9);
    return (s == '0) ? 32'h0000_0001 : s;
  endfunction
endpackage

// File: rtl/es_lfsr.sv
module es_lfsr
  import es_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] value_o
);
  logic [LFSR_W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    s_q <= SEED;
    else if (step) s_q <= lfsr_advance(s_q);
  end

  assign value_o = s_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) value_o != '0); // R3
endmodule

// File: rtl/es_stall_cnt.sv
module es_stall_cnt #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic last_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST); // R9
endmodule

// File: rtl/es_best_keep.sv
module es_best_keep #(
  parameter int CW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          offer,
  input  logic          force_take,
  input  logic [CW-1:0] cand_i,
  input  logic [FW-1:0] cand_fit_i,
  output logic [CW-1:0] chrom_o,
  output logic [FW-1:0] fit_o,
  output logic          took_o
);
  logic [CW-1:0] chrom_q;
  logic [FW-1:0] fit_q;

  // strictly-greater unsigned fitness wins; ties keep the incumbent
  function automatic logic beats(input logic [FW-1:0] challenger, input logic [FW-1:0] holder);
    return challenger > holder;
  endfunction

  assign took_o = offer && (force_take || beats(cand_fit_i, fit_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chrom_q <= '0;
      fit_q   <= '0;
    end else if (took_o) begin
      chrom_q <= cand_i;
      fit_q   <= cand_fit_i;
    end
  end

  assign chrom_o = chrom_q;
  assign fit_o   = fit_q;

  AST_KEEP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    took_o |=> (fit_o == $past(cand_fit_i)) && (chrom_o == $past(cand_i))); // R5
  AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !took_o |=> $stable(fit_o) && $stable(chrom_o)); // R7
endmodule

// File: rtl/es_search_top.sv
module es_search_top
  import es_pkg::*;
#(
  parameter int                CHROM_W = 32,
  parameter int                FIT_W   = 32,
  parameter int                POP_N   = 8,
  parameter int                ROUND_M = 10,
  parameter int                K_GENS  = 5,
  parameter int                T_GENS  = 4,
  parameter logic [LFSR_W-1:0] SEED    = 32'hACE1_2468
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CHROM_W-1:0] cand_o,
  output logic               cand_valid_o,
  input  logic [FIT_W-1:0]   fit_i,
  output logic [CHROM_W-1:0] mut_base_o,
  output logic               mut_req_o,
  input  logic [CHROM_W-1:0] mut_cand_i,
  output logic               mut_shrink_o,
  output logic               mut_restart_o,
  output logic [CHROM_W-1:0] best_chrom_o,
  output logic [FIT_W-1:0]   best_fit_o
);
  localparam int NLANE = (CHROM_W + LFSR_W - 1) / LFSR_W;

  es_state_e state_q, state_d;

  // state decode, brought out for assertions
  logic st_idle, st_seed_w, st_pop_w, st_mgen, st_mut_w, st_prom, st_fin, st_ev;
  assign st_idle   = (state_q == ST_IDLE);
  assign st_seed_w = (state_q == ST_SEED_W);
  assign st_pop_w  = (state_q == ST_POP_W);
  assign st_mgen   = (state_q == ST_MUT_GEN);
  assign st_mut_w  = (state_q == ST_MUT_W);
  assign st_prom   = (state_q == ST_PROMOTE);
  assign st_fin    = (state_q == ST_FIN);
  assign st_ev     = (state_q == ST_SEED_EV) || (state_q == ST_POP_EV) || (state_q == ST_MUT_EV);

  // random source, one lane per 32 bits of chromosome
  logic [NLANE*LFSR_W-1:0] rnd_wide;
  logic                    draw;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    es_lfsr #(.SEED(lane_seed(SEED, g))) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (draw),
      .value_o (rnd_wide[g*LFSR_W +: LFSR_W])
    );
  end

  // event wires
  logic pop_last, round_last, k_last, t_last;
  logic loc_took, glob_took;
  logic round_hit_q, loc_empty_q;
  logic improved, round_end, shrink_w, local_done, fin_w, restart_w;
  logic [CHROM_W-1:0] cand_q, loc_chrom, glob_chrom;
  logic [FIT_W-1:0]   loc_fit, glob_fit;

  assign restart_w  = st_pop_w && pop_last;
  assign improved   = round_hit_q || loc_took;
  assign round_end  = st_mut_w && round_last;
  assign shrink_w   = round_end && !improved;
  assign local_done = shrink_w && k_last;
  assign fin_w      = st_prom && !glob_took && t_last;

  assign draw = (st_idle && start_i) || st_seed_w ||
                (st_pop_w && !pop_last) || (st_prom && !fin_w);

  // stall and phase counters
  es_stall_cnt #(.LIMIT(POP_N)) u_pop_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_idle), .adv(st_pop_w), .last_o(pop_last)
  );
  es_stall_cnt #(.LIMIT(ROUND_M)) u_round_cnt (
    .clk(clk), .rst_n(rst_n), .clr(restart_w), .adv(st_mut_w), .last_o(round_last)
  );
  es_stall_cnt #(.LIMIT(K_GENS)) u_k_cnt (
    .clk(clk), .rst_n(rst_n), .clr(restart_w || (round_end && improved)),
    .adv(shrink_w), .last_o(k_last)
  );
  es_stall_cnt #(.LIMIT(T_GENS)) u_t_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_idle || (st_prom && glob_took)),
    .adv(st_prom && !glob_took), .last_o(t_last)
  );

  // local and global records
  es_best_keep #(.CW(CHROM_W), .FW(FIT_W)) u_loc (
    .clk        (clk),
    .rst_n      (rst_n),
    .offer      (st_pop_w || st_mut_w),
    .force_take (st_pop_w && loc_empty_q),
    .cand_i     (cand_q),
    .cand_fit_i (fit_i),
    .chrom_o    (loc_chrom),
    .fit_o      (loc_fit),
    .took_o     (loc_took)
  );

  es_best_keep #(.CW(CHROM_W), .FW(FIT_W)) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .offer      (st_seed_w || st_prom),
    .force_take (st_seed_w),
    .cand_i     (st_seed_w ? cand_q : loc_chrom),
    .cand_fit_i (st_seed_w ? fit_i : loc_fit),
    .chrom_o    (glob_chrom),
    .fit_o      (glob_fit),
    .took_o     (glob_took)
  );

  // candidate register and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cand_q      <= '0;
      round_hit_q <= 1'b0;
      loc_empty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (draw)         cand_q <= rnd_wide[CHROM_W-1:0];
      else if (st_mgen) cand_q <= mut_cand_i;

      if (restart_w || round_end)   round_hit_q <= 1'b0;
      else if (st_mut_w && loc_took) round_hit_q <= 1'b1;

      if (st_seed_w || (st_prom && !fin_w)) loc_empty_q <= 1'b1;
      else if (st_pop_w)                    loc_empty_q <= 1'b0;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SEED_EV;
      ST_SEED_EV: state_d = ST_SEED_W;
      ST_SEED_W:  state_d = ST_POP_EV;
      ST_POP_EV:  state_d = ST_POP_W;
      ST_POP_W:   state_d = pop_last ? ST_MUT_GEN : ST_POP_EV;
      ST_MUT_GEN: state_d = ST_MUT_EV;
      ST_MUT_EV:  state_d = ST_MUT_W;
      ST_MUT_W:   state_d = local_done ? ST_PROMOTE : ST_MUT_GEN;
      ST_PROMOTE: state_d = fin_w ? ST_FIN : ST_POP_EV;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign busy_o        = !st_idle;
  assign done_o        = st_fin;
  assign cand_o        = cand_q;
  assign cand_valid_o  = st_ev;
  assign mut_base_o    = loc_chrom;
  assign mut_req_o     = st_mgen;
  assign mut_shrink_o  = shrink_w;
  assign mut_restart_o = restart_w;
  assign best_chrom_o  = glob_chrom;
  assign best_fit_o    = glob_fit;

  // phase flags for monotonicity checks
  logic in_mut, glob_live;
  assign in_mut    = st_mgen || (state_q == ST_MUT_EV) || st_mut_w;
  assign glob_live = !st_idle && (state_q != ST_SEED_EV) && !st_seed_w;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_BEST_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !start_i) |=> $stable(best_chrom_o) && $stable(best_fit_o)); // R12
  AST_CAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid_o |=> $stable(cand_o) && !cand_valid_o); // R6
  AST_REQ_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    mut_req_o |=> cand_valid_o && (cand_o == $past(mut_cand_i))); // R7
  AST_SHRINK_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    mut_shrink_o |-> $past(cand_valid_o)); // R8
  AST_LOC_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mut && $past(in_mut)) |-> loc_fit >= $past(loc_fit)); // R7
  AST_GLOB_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_live && $past(glob_live)) |-> glob_fit >= $past(glob_fit)); // R11
endmodule

// File: tb/es_search_top_bench.sv
module es_search_top_bench;
  localparam int          N  = 8;
  localparam int          M  = 10;
  localparam int          K  = 5;
  localparam int          T  = 4;
  localparam logic [31:0] SD = 32'hACE1_2468;
  localparam int          W0 = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, cand_valid, mut_req, mut_shrink, mut_restart;
  logic [31:0] cand, fit, mut_base, mut_cand, best_chrom, best_fit;

  always #2.5 clk = ~clk;

  int          mode = 0;
  logic [31:0] target = '0;
  int          n_chk = 0, n_fail = 0;

  function automatic logic [31:0] fitf(input int md, input logic [31:0] tg, input logic [31:0] x);
    case (md)
      0:       return 32'($countones(~(x ^ tg)));
      1:       return x;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] lfsr_nx(input logic [31:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[30:0], fb};
  endfunction

  function automatic logic [31:0] xs_nx(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  // external fitness and mutation unit
  logic [31:0] m_rng = 32'h1234_5678;
  int          m_w   = W0;
  assign fit      = fitf(mode, target, cand);
  assign mut_cand = mut_base ^ (m_rng & msk(m_w));
  always @(posedge clk) begin
    if (mut_req) m_rng <= xs_nx(m_rng);
    if (mut_restart)     m_w <= W0;
    else if (mut_shrink) m_w <= (m_w > 1) ? m_w - 1 : 1;
  end

  es_search_top u_es_search_top (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .cand_o(cand), .cand_valid_o(cand_valid), .fit_i(fit),
    .mut_base_o(mut_base), .mut_req_o(mut_req), .mut_cand_i(mut_cand),
    .mut_shrink_o(mut_shrink), .mut_restart_o(mut_restart),
    .best_chrom_o(best_chrom), .best_fit_o(best_fit)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // scoreboard queues
  logic [31:0] q_val[$];
  int          q_kind[$];
  logic [31:0] r_lfsr = SD;
  logic [31:0] r_rng  = 32'h1234_5678;
  int          r_w    = W0;

  task automatic push(input logic [31:0] v, input int kd);
    q_val.push_back(v);
    q_kind.push_back(kd);
  endtask

  // transaction model of one run, from the requirements
  task automatic model_run(output logic [31:0] eb, output logic [31:0] ef,
                           output int esh, output int ers);
    logic [31:0] g, gf, l, lf, c;
    int tst, ks;
    bit hit;
    esh = 0; ers = 0;
    g = r_lfsr; gf = fitf(mode, target, g); r_lfsr = lfsr_nx(r_lfsr); push(g, 4); // R4
    tst = 0;
    forever begin
      l = '0; lf = '0;
      for (int i = 0; i < N; i++) begin // R5
        c = r_lfsr; r_lfsr = lfsr_nx(r_lfsr); push(c, 5);
        if (i == 0 || fitf(mode, target, c) > lf) begin l = c; lf = fitf(mode, target, c); end
      end
      r_w = W0; ers++; // R10
      ks = 0;
      forever begin
        hit = 0;
        for (int j = 0; j < M; j++) begin // R7
          c = l ^ (r_rng & msk(r_w)); r_rng = xs_nx(r_rng); push(c, 7);
          if (fitf(mode, target, c) > lf) begin l = c; lf = fitf(mode, target, c); hit = 1; end
        end
        if (hit) ks = 0;
        else begin // R8, R9
          esh++; r_w = (r_w > 1) ? r_w - 1 : 1; ks++;
          if (ks == K) break;
        end
      end
      if (lf > gf) begin g = l; gf = lf; tst = 0; end // R11
      else begin tst++; if (tst == T) break; end
    end
    eb = g; ef = gf;
  endtask

  // monitor
  int          done_cnt = 0, shr_cnt = 0, rst_cnt = 0;
  bit          hold_chk = 0, first_seen = 0;
  logic [31:0] held, first_cand = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (mut_shrink) shr_cnt++;
      if (mut_restart) rst_cnt++;
      if (hold_chk) chk(cand == held && !cand_valid, "R6 candidate held for sampling", cand, held);
      hold_chk = 0;
      if (cand_valid) begin
        if (!first_seen) begin first_seen = 1; first_cand = cand; end
        if (q_val.size() == 0) chk(0, "R5 unexpected candidate", cand, '0);
        else begin
          logic [31:0] ev;
          int kd;
          ev = q_val.pop_front(); kd = q_kind.pop_front();
          case (kd)
            4:       chk(cand == ev, "R4 seed candidate", cand, ev);
            5:       chk(cand == ev, "R5 sampled candidate", cand, ev);
            default: chk(cand == ev, "R7 mutated candidate", cand, ev);
          endcase
        end
        held = cand; hold_chk = 1;
      end
    end
  end

  // watchdog
  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) wd_hit <= 1;
  end

  task automatic run_search(input int md, input logic [31:0] tg, input bit poke, input string nm);
    logic [31:0] eb, ef, hb, hf;
    int esh, ers, s0, r0, d0;
    if (wd_hit) return;
    mode = md; target = tg;
    model_run(eb, ef, esh, ers);
    s0 = shr_cnt; r0 = rst_cnt; d0 = done_cnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy, "R2 busy after start", 32'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy, "R2 still busy before second start", 32'(busy), 1);
      start = 1;
      @(negedge clk) start = 0;
    end
    while (done_cnt == d0 && !wd_hit) @(negedge clk);
    if (wd_hit) return;
    $display("[TB] run %s finished at cycle %0d", nm, cyc);
    chk(best_chrom == eb, "R11 final best chromosome", best_chrom, eb);
    chk(best_fit == ef, "R11 final best fitness", best_fit, ef);
    chk(q_val.size() == 0, "R2 all expected candidates seen", 32'(q_val.size()), 0);
    chk(shr_cnt - s0 == esh, "R8 shrink pulse count", 32'(shr_cnt - s0), 32'(esh));
    chk(rst_cnt - r0 == ers, "R10 restart pulse count", 32'(rst_cnt - r0), 32'(ers));
    hb = best_chrom; hf = best_fit;
    repeat (25) @(negedge clk);
    chk(done_cnt - d0 == 1, "R12 single done pulse", 32'(done_cnt - d0), 1);
    chk(best_chrom == hb && best_fit == hf, "R12 result held", best_chrom, hb);
    chk(!busy, "R2 idle after done", 32'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !cand_valid, "R1 control outputs low", {29'd0, busy, done, cand_valid}, 0);
    chk(!mut_req && !mut_shrink && !mut_restart, "R1 mutation strobes low",
        {29'd0, mut_req, mut_shrink, mut_restart}, 0);
    chk(best_chrom == 0 && best_fit == 0, "R1 best cleared", best_chrom, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy, "R2 stays idle without start", 32'(busy), 0);

    run_search(0, 32'h5A5A_C3C3, 1, "match-target with extra start");
    chk(first_cand == SD, "R3 first draw equals seed", first_cand, SD);
    run_search(2, 32'h0, 0, "constant fitness");
    chk(shr_cnt >= T * K, "R9 full stall rounds in constant run", 32'(shr_cnt), 32'(T * K));
    run_search(1, 32'h0, 0, "identity fitness");
    run_search(0, 32'h0F0F_1234, 0, "match-target second");

    if (wd_hit) chk(0, "R2 watchdog expired", 32'(cyc), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule